// File: doc/BRIEF.md
# Serial Control and Coefficient Loader

This block is the control port of a two-channel spatial filter. A host drives three wires (an active-low select, a shift clock and a data line) and writes one byte per transfer into one of four registers. One register holds the operating mode: which coefficient set the filter uses and how far its summed output is shifted down. A second register takes commands: it sets the upper bit of the coefficient write address, clears the write address counter, or starts a clear of the whole coefficient RAM. The remaining two registers take a 16-bit coefficient word, high byte first. Writing the low byte commits the word to RAM at the current address and advances the counter.

The three serial wires are sampled with the system clock through synchronizers, so the host clock must be several times slower than the system clock. The RAM clear writes zero to every address, one word each `CLR_STEP` clocks, and reports busy while it runs. The host must leave at least one sample period between two coefficient commits and wait for the clear to finish before loading; commits that arrive during a clear are dropped.

Top module: `coef_ctl_loader`

## Requirements
- R1: A transfer is taken while `ctl_csn` is low, one bit on each rising edge of `ctl_sck`, in the order A1, A0, RW, D0, D1 ... D7 (11 bits). It is applied after `ctl_csn` rises, and only if exactly 11 bits were shifted; a shorter or longer transfer changes nothing.
- R2: A transfer with RW = 1 changes nothing.
- R3: A write to address 00 loads `coef_sel` from D2..D0 and `shift_sel` from D4..D3; D7..D5 have no effect.
- R4: `src_download` is 1 exactly when `coef_sel` is 110, `src_bypass` is 1 exactly when `coef_sel` is 111; codes 000 to 101 drive both low.
- R5: A write to address 01 stores D0 as the upper RAM address bit, which forms the MSB of `ram_addr` on every later commit.
- R6: A write to address 01 with D1 = 1 resets the write address counter to 0.
- R7: A write to address 10 stores the high byte. A write to address 11 produces one single-cycle `ram_we` pulse with `ram_addr` = {upper bit, counter} and `ram_wdata` = {high byte, low byte}; the counter then increments and wraps from its maximum to 0.
- R8: A write to address 01 with D2 = 1 starts a RAM clear: `clr_busy` goes high and zero is written to every RAM address in ascending order from 0, one write per `CLR_STEP` clocks; `clr_busy` falls after the last one.
- R9: A low-byte write arriving while `clr_busy` is high produces no RAM write and leaves the counter unchanged.
- R10: After reset `coef_sel` is 000, `shift_sel` is 00, `clr_busy` is 0, no RAM write is issued, and the counter and upper bit are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_csn | input | 1 | Serial select, active low |
| ctl_sck | input | 1 | Serial shift clock |
| ctl_sdi | input | 1 | Serial data |
| coef_sel | output | 3 | Coefficient set code |
| shift_sel | output | 2 | Output down-shift amount |
| src_download | output | 1 | Downloaded coefficients chosen |
| src_bypass | output | 1 | Filter bypass chosen |
| ram_we | output | 1 | Coefficient RAM write strobe |
| ram_addr | output | CNT_W+1 | Coefficient RAM write address |
| ram_wdata | output | 16 | Coefficient RAM write data |
| clr_busy | output | 1 | RAM clear in progress |

## Verification
The bench builds the block with a 4-bit counter, so the address wrap is reached after sixteen commits and a full clear sweep covers only 32 addresses. It sets `CLR_STEP` to 8, which stretches that sweep to 256 clocks, long enough for a complete serial transfer to land inside it and exercise the dropped-commit path. The sweep order, the zero data and the unchanged counter after the dropped commit are all visible at the RAM port.

// File: rtl/coef_ctl_pkg.sv
package coef_ctl_pkg;

  localparam int FRAME_W = 11;

  typedef enum logic [1:0] {
    SEL_MODE = 2'b00,
    SEL_CMD  = 2'b01,
    SEL_HI   = 2'b10,
    SEL_LO   = 2'b11
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic       rd;
    logic [7:0] data;
  } frame_t;

  // First bit on the wire ends in raw[0] (right-shifting receiver).
  function automatic frame_t unpack_frame(logic [FRAME_W-1:0] raw);
    frame_t f;
    f.sel  = reg_sel_e'({raw[0], raw[1]});
    f.rd   = raw[2];
    f.data = raw[10:3];
    return f;
  endfunction

  // {download, bypass}
  function automatic logic [1:0] src_of(logic [2:0] sel);
    return {sel == 3'b110, sel == 3'b111};
  endfunction

endpackage

// File: rtl/coef_ctl_rx.sv
module coef_ctl_rx
  import coef_ctl_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csn,
  input  logic               sck,
  input  logic               sdi,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_raw
);

  logic [SYNC_N-1:0] csn_q, sck_q, sdi_q;
  logic              csn_d, sck_d;
  logic [3:0]        bcnt;

  logic csn_now, sck_now, sdi_now;
  logic sck_rise, csn_fall, csn_rise;

  assign csn_now  = csn_q[SYNC_N-1];
  assign sck_now  = sck_q[SYNC_N-1];
  assign sdi_now  = sdi_q[SYNC_N-1];
  assign sck_rise = sck_now & ~sck_d;
  assign csn_fall = ~csn_now & csn_d;
  assign csn_rise = csn_now & ~csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= '1;
      sck_q <= '0;
      sdi_q <= '0;
      csn_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      csn_q <= {csn_q[SYNC_N-2:0], csn};
      sck_q <= {sck_q[SYNC_N-2:0], sck};
      sdi_q <= {sdi_q[SYNC_N-2:0], sdi};
      csn_d <= csn_now;
      sck_d <= sck_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt      <= '0;
      frame_raw <= '0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= csn_rise && (bcnt == 4'(FRAME_W));
      if (csn_fall) begin
        bcnt <= '0;
      end else if (sck_rise && !csn_now) begin
        frame_raw <= {sdi_now, frame_raw[FRAME_W-1:1]};
        if (bcnt != 4'hF) bcnt <= bcnt + 4'd1;
      end
    end
  end

endmodule

// File: rtl/coef_ctl_regs.sv
module coef_ctl_regs
  import coef_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_vld,
  input  logic [FRAME_W-1:0] frame_raw,
  output logic [2:0]         coef_sel,
  output logic [1:0]         shift_sel,
  output logic               upper_bit,
  output logic [7:0]         hi_byte,
  output logic [7:0]         lo_byte,
  output logic               evt_mode,
  output logic               evt_cnt_clr,
  output logic               evt_ram_clr,
  output logic               evt_lo
);

  frame_t f;
  logic   accept;

  assign f      = unpack_frame(frame_raw);
  assign accept = frame_vld && !f.rd;

  assign evt_mode    = accept && (f.sel == SEL_MODE);
  assign evt_cnt_clr = accept && (f.sel == SEL_CMD) && f.data[1];
  assign evt_ram_clr = accept && (f.sel == SEL_CMD) && f.data[2];
  assign evt_lo      = accept && (f.sel == SEL_LO);
  assign lo_byte     = f.data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_sel  <= '0;
      shift_sel <= '0;
      upper_bit <= 1'b0;
      hi_byte   <= '0;
    end else if (accept) begin
      unique case (f.sel)
        SEL_MODE: begin
          coef_sel  <= f.data[2:0];
          shift_sel <= f.data[4:3];
        end
        SEL_CMD: upper_bit <= f.data[0];
        SEL_HI:  hi_byte   <= f.data;
        SEL_LO:  ;
      endcase
    end
  end

endmodule

// File: rtl/coef_ctl_writer.sv
module coef_ctl_writer #(
  parameter int CNT_W    = 7,
  parameter int CLR_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_cnt_clr,
  input  logic             evt_ram_clr,
  input  logic             evt_lo,
  input  logic             upper_bit,
  input  logic [7:0]       hi_byte,
  input  logic [7:0]       lo_byte,
  output logic             ram_we,
  output logic [CNT_W:0]   ram_addr,
  output logic [15:0]      ram_wdata,
  output logic             busy,
  output logic [CNT_W-1:0] wr_cnt
);

  localparam int AW    = CNT_W + 1;
  localparam int DIV_W = (CLR_STEP > 1) ? $clog2(CLR_STEP) : 1;
  localparam logic [AW-1:0]    LAST_IDX = '1;
  localparam logic [DIV_W-1:0] DIV_TOP  = DIV_W'(CLR_STEP - 1);

  logic             c_we;
  logic [AW-1:0]    c_addr;
  logic [15:0]      c_data;
  logic [AW-1:0]    clr_idx;
  logic [DIV_W-1:0] div;
  logic             step;
  logic             commit_ok;

  assign step      = busy && (div == DIV_TOP);
  assign commit_ok = evt_lo && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_we   <= 1'b0;
      c_addr <= '0;
      c_data <= '0;
      wr_cnt <= '0;
    end else begin
      c_we <= commit_ok;
      if (commit_ok) begin
        c_addr <= {upper_bit, wr_cnt};
        c_data <= {hi_byte, lo_byte};
        wr_cnt <= wr_cnt + 1'b1;
      end else if (evt_cnt_clr) begin
        wr_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      clr_idx <= '0;
      div     <= '0;
    end else if (evt_ram_clr && !busy) begin
      busy    <= 1'b1;
      clr_idx <= '0;
      div     <= '0;
    end else if (busy) begin
      div <= step ? '0 : div + 1'b1;
      if (step) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == LAST_IDX) busy <= 1'b0;
      end
    end
  end

  assign ram_we    = busy ? step    : c_we;
  assign ram_addr  = busy ? clr_idx : c_addr;
  assign ram_wdata = busy ? 16'h0   : c_data;

endmodule

// File: rtl/coef_ctl_loader.sv
module coef_ctl_loader
  import coef_ctl_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int CLR_STEP = 4,
  parameter int SYNC_N   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_csn,
  input  logic           ctl_sck,
  input  logic           ctl_sdi,
  output logic [2:0]     coef_sel,
  output logic [1:0]     shift_sel,
  output logic           src_download,
  output logic           src_bypass,
  output logic           ram_we,
  output logic [CNT_W:0] ram_addr,
  output logic [15:0]    ram_wdata,
  output logic           clr_busy
);

  logic               frame_vld;
  logic [FRAME_W-1:0] frame_raw;
  logic               upper_bit;
  logic [7:0]         hi_byte, lo_byte;
  logic               evt_mode, evt_cnt_clr, evt_ram_clr, evt_lo;
  logic [CNT_W-1:0]   wr_cnt;

  coef_ctl_rx #(.SYNC_N(SYNC_N)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn       (ctl_csn),
    .sck       (ctl_sck),
    .sdi       (ctl_sdi),
    .frame_vld (frame_vld),
    .frame_raw (frame_raw)
  );

  coef_ctl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_vld   (frame_vld),
    .frame_raw   (frame_raw),
    .coef_sel    (coef_sel),
    .shift_sel   (shift_sel),
    .upper_bit   (upper_bit),
    .hi_byte     (hi_byte),
    .lo_byte     (lo_byte),
    .evt_mode    (evt_mode),
    .evt_cnt_clr (evt_cnt_clr),
    .evt_ram_clr (evt_ram_clr),
    .evt_lo      (evt_lo)
  );

  coef_ctl_writer #(.CNT_W(CNT_W), .CLR_STEP(CLR_STEP)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_cnt_clr (evt_cnt_clr),
    .evt_ram_clr (evt_ram_clr),
    .evt_lo      (evt_lo),
    .upper_bit   (upper_bit),
    .hi_byte     (hi_byte),
    .lo_byte     (lo_byte),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .busy        (clr_busy),
    .wr_cnt      (wr_cnt)
  );

  assign {src_download, src_bypass} = src_of(coef_sel);

endmodule

// File: rtl/coef_ctl_loader_chk.sv
module coef_ctl_loader_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_lo,
  input logic             evt_mode,
  input logic             clr_busy,
  input logic [CNT_W-1:0] wr_cnt,
  input logic             ram_we,
  input logic [15:0]      ram_wdata,
  input logic [2:0]       coef_sel,
  input logic             src_download,
  input logic             src_bypass
);

  a_r9_busy_drops_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && evt_lo) |=> $stable(wr_cnt));

  a_r7_commit_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_busy && evt_lo) |=> (wr_cnt == CNT_W'($past(wr_cnt) + 1'b1)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !clr_busy) |=> !(ram_we && !clr_busy));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && ram_we) |-> (ram_wdata == 16'h0));

  a_r3_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_mode |=> $stable(coef_sel));

  a_r4_src_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_download, src_bypass}));

endmodule

bind coef_ctl_loader coef_ctl_loader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_lo       (evt_lo),
  .evt_mode     (evt_mode),
  .clr_busy     (clr_busy),
  .wr_cnt       (wr_cnt),
  .ram_we       (ram_we),
  .ram_wdata    (ram_wdata),
  .coef_sel     (coef_sel),
  .src_download (src_download),
  .src_bypass   (src_bypass)
);

// File: tb/coef_ctl_loader_test.sv
module coef_ctl_loader_test;

  localparam int CNT_W    = 4;
  localparam int CLR_STEP = 8;
  localparam int AW       = CNT_W + 1;
  localparam int NWORDS   = 1 << CNT_W;
  localparam int NCLR     = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [2:0]    coef_sel;
  logic [1:0]    shift_sel;
  logic          src_download, src_bypass, ram_we, clr_busy;
  logic [AW-1:0] ram_addr;
  logic [15:0]   ram_wdata;

  always #2 clk = ~clk;

  coef_ctl_loader #(.CNT_W(CNT_W), .CLR_STEP(CLR_STEP)) uut (
    .clk (clk), .rst_n (rst_n),
    .ctl_csn (csn), .ctl_sck (sck), .ctl_sdi (sdi),
    .coef_sel (coef_sel), .shift_sel (shift_sel),
    .src_download (src_download), .src_bypass (src_bypass),
    .ram_we (ram_we), .ram_addr (ram_addr), .ram_wdata (ram_wdata),
    .clr_busy (clr_busy)
  );

  int n_checks = 0, n_fail = 0;
  int wr_nb = 0, clr_next = 0, clr_bad = 0;
  logic [AW-1:0] last_addr = '0;
  logic [15:0]   last_data = '0;

  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (clr_busy) begin
        if (ram_addr != AW'(clr_next) || ram_wdata != 16'h0) clr_bad++;
        clr_next++;
      end else begin
        wr_nb++;
        last_addr = ram_addr;
        last_data = ram_wdata;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Sends nbits of the sequence A1, A0, RW, D0..D7, then extra zeros.
  task automatic send(logic [1:0] a, logic rw, logic [7:0] d, int nbits = 11);
    logic [11:0] seq;
    seq = {1'b0, d[7], d[6], d[5], d[4], d[3], d[2], d[1], d[0], rw, a[0], a[1]};
    csn = 1'b0;
    waitc(4);
    for (int k = 0; k < nbits; k++) begin
      sdi = seq[k];
      waitc(4);
      sck = 1'b1;
      waitc(4);
      sck = 1'b0;
    end
    waitc(4);
    csn = 1'b1;
    waitc(10);
  endtask

  task automatic t_reset();
    check("R10 coef_sel", coef_sel, 0);
    check("R10 shift_sel", shift_sel, 0);
    check("R10 busy", clr_busy, 0);
    check("R10 no write", wr_nb + clr_next, 0);
    check("R4 src at reset", {src_download, src_bypass}, 0);
  endtask

  task automatic t_mode();
    send(2'b00, 1'b0, 8'b111_10_101);
    check("R3 coef_sel", coef_sel, 3'b101);
    check("R3 shift_sel", shift_sel, 2'b10);
    check("R4 code 101", {src_download, src_bypass}, 2'b00);
    send(2'b00, 1'b0, 8'b000_01_110);
    check("R4 download", {src_download, src_bypass}, 2'b10);
    check("R3 shift 01", shift_sel, 2'b01);
    send(2'b00, 1'b0, 8'b000_11_111);
    check("R4 bypass", {src_download, src_bypass}, 2'b01);
    send(2'b00, 1'b0, 8'b000_00_011);
    check("R4 code 011", {src_download, src_bypass}, 2'b00);
  endtask

  task automatic t_reject();
    send(2'b00, 1'b1, 8'h1F);
    check("R2 read bit ignored", {coef_sel, shift_sel}, {3'b011, 2'b00});
    send(2'b00, 1'b0, 8'h1F, 10);
    check("R1 short frame ignored", {coef_sel, shift_sel}, {3'b011, 2'b00});
    send(2'b00, 1'b0, 8'h1F, 12);
    check("R1 long frame ignored", {coef_sel, shift_sel}, {3'b011, 2'b00});
    send(2'b11, 1'b1, 8'h55);
    check("R2 read of low byte no write", wr_nb, 0);
  endtask

  task automatic t_commit();
    send(2'b01, 1'b0, 8'h02);
    send(2'b10, 1'b0, 8'hAB);
    send(2'b11, 1'b0, 8'hCD);
    check("R7 one write", wr_nb, 1);
    check("R7 addr 0", last_addr, 0);
    check("R7 data", last_data, 16'hABCD);
    send(2'b11, 1'b0, 8'h12);
    check("R7 addr advances", last_addr, 1);
    check("R7 high byte kept", last_data, 16'hAB12);
    send(2'b01, 1'b0, 8'h01);
    send(2'b11, 1'b0, 8'h34);
    check("R5 upper bit", last_addr, (1 << CNT_W) | 2);
    send(2'b01, 1'b0, 8'h03);
    send(2'b11, 1'b0, 8'h56);
    check("R6 counter cleared", last_addr, (1 << CNT_W));
    check("R7 write count", wr_nb, 4);
  endtask

  task automatic t_wrap();
    send(2'b01, 1'b0, 8'h02);
    for (int i = 0; i < NWORDS; i++) send(2'b11, 1'b0, 8'(i));
    check("R7 last before wrap", last_addr, NWORDS - 1);
    send(2'b11, 1'b0, 8'hEE);
    check("R7 wraps to 0", last_addr, 0);
  endtask

  task automatic t_clear();
    int base;
    send(2'b01, 1'b0, 8'h04);
    check("R8 busy high", clr_busy, 1);
    base = wr_nb;
    send(2'b11, 1'b0, 8'h77);
    check("R9 still busy at drop", clr_busy, 1);
    for (int i = 0; i < 2000 && clr_busy; i++) waitc(1);
    check("R8 busy falls", clr_busy, 0);
    check("R8 all addresses cleared", clr_next, NCLR);
    check("R8 order and zero data", clr_bad, 0);
    check("R9 no write while busy", wr_nb, base);
    send(2'b11, 1'b0, 8'h99);
    check("R9 counter unchanged", last_addr, 1);
    check("R9 data after clear", last_data, 16'hAB99);
  endtask

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    t_reset();
    t_mode();
    t_reject();
    t_commit();
    t_wrap();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule